// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers eleven peripheral interrupt sources into one active-low interrupt line for a processor core. It also keeps a vector register that always names the highest-priority source that is pending and enabled. Each vector is an absolute program address, `0x30 + 4*index`, where index 0 has the highest priority. The core's single handler reads the vector and jumps through it. Each read retires the source it names.

Six device request lines and twelve general-purpose I/O lines arrive as rising-edge requests. I/O lines 0–3 each own a source. I/O lines 4–11 share one merged source, and a flag register records which of those lines fired. An 11-bit mask register enables each source individually. A masked source still latches its request, so it appears as soon as its mask bit is set.

Top module: `prio_vec_intc`

## Requirements
- R1: After a synchronous active-low reset: `irq_n`=1, `vec_q`=0x30, `flag_q`=0, `mask_q`=0.
- R2: Source index i drives vector 0x30+4*i. The index order, highest priority first, is: 0 ADC end-of-conversion (`dev_req[0]`), 1 PWM sync (`dev_req[1]`), 2 loop-timer timeout (`dev_req[2]`), 3 merged I/O lines 4–11, 4 counter error (`dev_req[3]`), 5 event timer (`dev_req[4]`), 6–9 I/O lines 0–3, 10 PWM trip (`dev_req[5]`).
- R3: When several enabled sources are pending, `vec_q` shows the one with the lowest index.
- R4: Mask bit i enables source i, and a write through `mask_we`/`mask_wdata` acts at the same clock edge. A masked source latches as pending but affects neither `irq_n` nor `vec_q` until its bit is set.
- R5: Only a rising edge on a request line sets a pending latch. A level held high after its source is retired does not set it again.
- R6: A `vec_rd` while `irq_n`=0 retires the source that `vec_q` names. At the same edge `vec_q` moves to the next pending enabled source, and `irq_n` stays low with no high cycle between.
- R7: I/O lines 0–3 set sources 6–9 and leave `flag_q` untouched. I/O line 4+k sets `flag_q[k]`, and source 3 is pending exactly while `flag_q` is nonzero.
- R8: `flag_rd` clears `flag_q`, except for bits whose line rises in that same cycle. A `vec_rd` does not retire source 3.
- R9: While no enabled source is pending, `irq_n`=1 and `vec_q` keeps its last value.
- R10: A request rising before edge k shows on `irq_n`/`vec_q` right after edge k. A new edge on a source wins over a retiring read of it in the same cycle.
- R11: A `vec_rd` while `irq_n`=1 changes no pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_req | input | 6 | Device request lines, rising-edge sensitive |
| io_req | input | 12 | General-purpose I/O request lines, rising-edge sensitive |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 11 | Mask write data, bit i enables source i |
| mask_q | output | 11 | Current mask register |
| vec_rd | input | 1 | Vector read strobe (retires the named source) |
| vec_q | output | 8 | Vector register |
| flag_rd | input | 1 | Flag read strobe (clears the flags) |
| flag_q | output | 8 | Shared I/O line flags, bit k for line 4+k |
| irq_n | output | 1 | Active-low interrupt to the core |

## Verification
A stuck or lost pending latch shows at the ports within one cycle: `irq_n` rises too early or stays low after the last retire, or `vec_q` jumps to the wrong next vector after a read. A wrong priority order or a wrong slot mapping shows on the first `vec_q` sample after the requests arrive. The bench therefore sweeps every single source and every pair of sources, and it retires each source in turn. A flag or mask fault appears once the merged source or a masked source is retired or unmasked.

// File: rtl/intc_pkg.sv
// Package: source slot numbering shared by the interrupt controller.
// Assumes the fixed eleven-slot priority layout; index 0 is highest.
package intc_pkg;
    localparam int SRC_COUNT     = 11;
    localparam int SRC_SHARED    = 3;   // merged I/O lines slot
    localparam int SRC_IO_FIRST  = 6;   // first dedicated I/O slot
    localparam int DEV_COUNT     = 6;

    // Maps a device request line to its priority slot.
    function automatic int dev_slot(input int d);
        if (d < 3)      return d;        // adc, pwm sync, loop timeout
        else if (d < 5) return d + 1;    // counter error, event timer
        else            return 10;       // pwm trip
    endfunction
endpackage

// File: rtl/intc_edge_det.sv
// Module: rising-edge detector for a bundle of level request lines.
// Assumes lines are synchronous to clk; lines high out of reset count as an edge.
module intc_edge_det #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    // Remember last cycle's levels.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/intc_io_merge.sv
// Module: flag register for the shared I/O lines feeding one merged source.
// Assumes a read clears all flags; a line rising in the read cycle survives.
module intc_io_merge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rise_i,
    input  logic         rd_i,
    output logic [W-1:0] flag_q_o,
    output logic         any_nxt_o
);
    logic [W-1:0] flag_nxt;

    // Next flags: clear on read, new edges always set.
    always_comb begin
        flag_nxt = (rd_i ? '0 : flag_q_o) | rise_i;
    end

    // Flag storage.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q_o <= '0;
        else        flag_q_o <= flag_nxt;
    end

    assign any_nxt_o = |flag_nxt;

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && rise_i == '0) |=> (flag_q_o == '0));
    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i != '0) |=> ((flag_q_o & $past(rise_i)) == $past(rise_i)));
endmodule

// File: rtl/intc_pend_bank.sv
// Module: per-source pending latches; one slot is a level fed from outside.
// Assumes set wins over clear in the same cycle.
module intc_pend_bank #(
    parameter int N       = 11,
    parameter int LVL_IDX = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic         lvl_i,
    output logic [N-1:0] pend_nxt_o,
    output logic [N-1:0] pend_q_o
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        if (i == LVL_IDX) begin : g_lvl
            // Level slot: follows the merged flag state directly.
            assign pend_nxt_o[i] = lvl_i;
            logic unused_lvl;
            assign unused_lvl = set_i[i] ^ clr_i[i];
        end else begin : g_latch
            // Latch slot: set on edge, held until retired.
            assign pend_nxt_o[i] = set_i[i] | (pend_q_o[i] & ~clr_i[i]);

            // R5
            rise_from_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(pend_q_o[i]) |-> $past(set_i[i]));
            // R6
            retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[i] && !set_i[i]) |=> !pend_q_o[i]);
        end
    end

    // Pending storage.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q_o <= '0;
        else        pend_q_o <= pend_nxt_o;
    end
endmodule

// File: rtl/intc_prio_enc.sv
// Module: fixed-priority finder, lowest set index wins.
// Assumes IDX_W can hold N-1.
module intc_prio_enc #(
    parameter int N     = 11,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             valid_o
);
    // Scan from lowest priority up so the lowest index is written last.
    always_comb begin
        idx_o   = '0;
        valid_o = |req_i;
        for (int s = N - 1; s >= 0; s--) begin
            if (req_i[s]) idx_o = IDX_W'(s);
        end
    end
endmodule

// File: rtl/prio_vec_intc.sv
// Module: fixed-priority vectored interrupt controller top.
// Collects device and I/O requests into prioritized pending slots, drives an
// active-low interrupt and a vector register (base + step*index).
// Assumes all inputs are synchronous to clk and VEC_STEP is a power of two >= 2.
module prio_vec_intc
    import intc_pkg::*;
#(
    parameter int NUM_SRC   = SRC_COUNT,
    parameter int NUM_DEV   = DEV_COUNT,
    parameter int NUM_IO    = 12,
    parameter int NUM_IO_DIRECT = 4,
    parameter int VEC_W     = 8,
    parameter int VEC_BASE  = 'h30,
    parameter int VEC_STEP  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_DEV-1:0]   dev_req,
    input  logic [NUM_IO-1:0]    io_req,
    input  logic                 mask_we,
    input  logic [NUM_SRC-1:0]   mask_wdata,
    output logic [NUM_SRC-1:0]   mask_q,
    input  logic                 vec_rd,
    output logic [VEC_W-1:0]     vec_q,
    input  logic                 flag_rd,
    output logic [NUM_IO-NUM_IO_DIRECT-1:0] flag_q,
    output logic                 irq_n
);
    localparam int NUM_SHARED = NUM_IO - NUM_IO_DIRECT;
    localparam int IDX_W      = $clog2(NUM_SRC);
    localparam int STEP_SH    = $clog2(VEC_STEP);

    logic [NUM_DEV-1:0]    dev_rise;
    logic [NUM_IO-1:0]     io_rise;
    logic [NUM_SRC-1:0]    src_set, src_clr;
    logic [NUM_SRC-1:0]    pend_nxt, pend_q, mask_nxt, enabled_nxt;
    logic                  shared_any_nxt;
    logic [IDX_W-1:0]      win_idx, vec_idx;
    logic                  win_valid;
    logic [VEC_W-1:0]      vec_off;

    intc_edge_det #(.W(NUM_DEV)) u_dev_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(dev_req), .rise_o(dev_rise));

    intc_edge_det #(.W(NUM_IO)) u_io_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(io_req), .rise_o(io_rise));

    intc_io_merge #(.W(NUM_SHARED)) u_merge (
        .clk(clk), .rst_n(rst_n),
        .rise_i(io_rise[NUM_IO-1:NUM_IO_DIRECT]),
        .rd_i(flag_rd), .flag_q_o(flag_q), .any_nxt_o(shared_any_nxt));

    // Route edges into their priority slots.
    always_comb begin
        src_set = '0;
        for (int d = 0; d < NUM_DEV; d++) src_set[dev_slot(d)] = dev_rise[d];
        for (int k = 0; k < NUM_IO_DIRECT; k++) src_set[SRC_IO_FIRST + k] = io_rise[k];
    end

    // Decode the slot currently shown in the vector register.
    assign vec_off = vec_q - VEC_W'(VEC_BASE);
    assign vec_idx = IDX_W'(vec_off >> STEP_SH);

    // Retire the shown slot on a read while the interrupt is active.
    always_comb begin
        src_clr = '0;
        if (vec_rd && !irq_n && (int'(vec_idx) < NUM_SRC)) src_clr[vec_idx] = 1'b1;
    end

    intc_pend_bank #(.N(NUM_SRC), .LVL_IDX(SRC_SHARED)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_i(src_set), .clr_i(src_clr),
        .lvl_i(shared_any_nxt), .pend_nxt_o(pend_nxt), .pend_q_o(pend_q));

    // Mask takes effect at the edge of its write.
    assign mask_nxt = mask_we ? mask_wdata : mask_q;

    // Mask register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_nxt;
    end

    assign enabled_nxt = pend_nxt & mask_nxt;

    intc_prio_enc #(.N(NUM_SRC), .IDX_W(IDX_W)) u_enc (
        .req_i(enabled_nxt), .idx_o(win_idx), .valid_o(win_valid));

    // Interrupt line and vector register, updated from next-state pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_n <= 1'b1;
            vec_q <= VEC_W'(VEC_BASE);
        end else begin
            irq_n <= ~win_valid;
            if (win_valid) vec_q <= VEC_W'(VEC_BASE + (int'(win_idx) << STEP_SH));
        end
    end

    // Slots of higher priority than the one shown.
    logic [NUM_SRC-1:0] above_mask;
    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) above_mask[s] = (s < int'(vec_idx));
    end

    // R2
    vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (vec_off[STEP_SH-1:0] == '0 && int'(vec_idx) < NUM_SRC));
    // R3
    vec_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (pend_q[vec_idx] && mask_q[vec_idx]
                    && ((pend_q & mask_q & above_mask) == '0)));
    // R4
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> irq_n);
    // R9
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n |-> $stable(vec_q));
    // R11
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_n && vec_rd && dev_rise == '0 && io_rise == '0 && !flag_rd)
        |=> (pend_q == $past(pend_q)));
endmodule

// File: tb/sim_prio_vec_intc.sv
`timescale 1ns/1ps
module sim_prio_vec_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  dev_req = '0;
    logic [11:0] io_req = '0;
    logic        mask_we = 1'b0;
    logic [10:0] mask_wdata = '0;
    logic [10:0] mask_q;
    logic        vec_rd = 1'b0;
    logic [7:0]  vec_q;
    logic        flag_rd = 1'b0;
    logic [7:0]  flag_q;
    logic        irq_n;

    int checks = 0;
    int errors = 0;
    int shared_sel = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    prio_vec_intc u0 (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .io_req(io_req),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .mask_q(mask_q),
        .vec_rd(vec_rd), .vec_q(vec_q), .flag_rd(flag_rd), .flag_q(flag_q),
        .irq_n(irq_n));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    function automatic int vec_of(input int idx);
        return 'h30 + 4 * idx;
    endfunction

    // Drive the request line belonging to slot idx.
    task automatic set_src(input int idx, input logic v);
        case (idx)
            0, 1, 2: dev_req[idx] = v;
            3:       io_req[4 + shared_sel] = v;
            4, 5:    dev_req[idx - 1] = v;
            6, 7, 8, 9: io_req[idx - 6] = v;
            default: dev_req[5] = v;
        endcase
    endtask

    task automatic pulse_src(input int idx);
        set_src(idx, 1'b1); cyc(); set_src(idx, 1'b0);
    endtask

    task automatic write_mask(input logic [10:0] m);
        mask_we = 1'b1; mask_wdata = m; cyc(); mask_we = 1'b0;
    endtask

    // Retire slot idx through the proper port.
    task automatic service(input int idx);
        if (idx == 3) begin flag_rd = 1'b1; cyc(); flag_rd = 1'b0; end
        else          begin vec_rd  = 1'b1; cyc(); vec_rd  = 1'b0; end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        check("R1 irq_n", irq_n, 1);
        check("R1 vec_q", vec_q, 'h30);
        check("R1 flag_q", flag_q, 0);
        check("R1 mask_q", mask_q, 0);

        write_mask(11'h7FF);
        check("R4 mask write", mask_q, 'h7FF);

        // Single-source sweep: R2 mapping, R10 latency, R7 flags, R6 retire
        for (int i = 0; i < 11; i++) begin
            shared_sel = i % 8;
            pulse_src(i);
            check("R10 irq after one edge", irq_n, 0);
            check("R2 vector of slot", vec_q, vec_of(i));
            if (i == 3) begin
                check("R7 shared flag bit", flag_q, 1 << shared_sel);
                vec_rd = 1'b1; cyc(); vec_rd = 1'b0;
                check("R8 vec read keeps merged", irq_n, 0);
                check("R8 merged flag kept", flag_q, 1 << shared_sel);
            end else begin
                check("R7 flags untouched", flag_q, 0);
            end
            service(i);
            check("R6 retired", irq_n, 1);
            check("R9 vector held", vec_q, vec_of(i));
        end

        // Pair sweep: R3 priority, R6 no high pulse between
        for (int i = 0; i < 11; i++) begin
            for (int j = i + 1; j < 11; j++) begin
                shared_sel = (i + j) % 8;
                set_src(i, 1'b1); set_src(j, 1'b1); cyc();
                set_src(i, 1'b0); set_src(j, 1'b0);
                check("R3 higher wins", vec_q, vec_of(i));
                service(i);
                check("R6 irq stays low", irq_n, 0);
                check("R6 next vector", vec_q, vec_of(j));
                service(j);
                check("R6 all retired", irq_n, 1);
            end
        end

        // R11 and R4: masked latch survives an idle read
        pulse_src(0); service(0);
        write_mask(11'h000);
        pulse_src(0);
        check("R4 masked no irq", irq_n, 1);
        check("R9 vec held while masked", vec_q, 'h30);
        vec_rd = 1'b1; cyc(); vec_rd = 1'b0;
        write_mask(11'h7FF);
        check("R11 idle read kept pending", irq_n, 0);
        check("R4 unmasked vector", vec_q, 'h30);
        service(0);

        // R4 partial mask: lower slot shown while higher masked
        write_mask(11'h7FE);
        set_src(0, 1'b1); set_src(5, 1'b1); cyc();
        set_src(0, 1'b0); set_src(5, 1'b0);
        check("R4 masked higher skipped", vec_q, vec_of(5));
        service(5);
        check("R4 only masked left", irq_n, 1);
        write_mask(11'h7FF);
        check("R4 unmask shows slot 0", vec_q, 'h30);
        service(0);
        check("R4 cleared", irq_n, 1);

        // R5 held level does not re-raise
        set_src(0, 1'b1); cyc();
        check("R5 first edge", irq_n, 0);
        service(0); cyc(); cyc();
        check("R5 level held no retrigger", irq_n, 1);
        set_src(0, 1'b0); cyc(); set_src(0, 1'b1); cyc();
        check("R5 new edge", irq_n, 0);
        set_src(0, 1'b0); service(0);

        // R10 set wins over retire in same cycle
        pulse_src(1); cyc();
        vec_rd = 1'b1; set_src(1, 1'b1); cyc();
        vec_rd = 1'b0; set_src(1, 1'b0);
        check("R10 set wins irq", irq_n, 0);
        check("R10 set wins vec", vec_q, vec_of(1));
        service(1);
        check("R10 retired", irq_n, 1);

        // R8 flag read with simultaneous new edge
        io_req[4] = 1'b1; io_req[9] = 1'b1; cyc();
        io_req[4] = 1'b0; io_req[9] = 1'b0;
        check("R7 two shared flags", flag_q, 'h21);
        flag_rd = 1'b1; io_req[11] = 1'b1; cyc();
        flag_rd = 1'b0; io_req[11] = 1'b0;
        check("R8 new edge survives read", flag_q, 'h80);
        check("R8 merged still pending", vec_q, 'h3C);
        check("R8 merged irq", irq_n, 0);
        flag_rd = 1'b1; cyc(); flag_rd = 1'b0;
        check("R8 flags cleared", flag_q, 0);
        check("R8 merged retired", irq_n, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule